// File: doc/BRIEF.md
# Multi-Mode Timer Channel

A single timer channel that counts in one of five operating modes picked by a 3-bit mode input: periodic interval, free-running capture, external event counting, single-shot count after a trigger, and a single-shot that measures a trigger pulse width. A one-bit detail input refines the mode. In the interval and capture modes it requests an interrupt and an output toggle at the instant counting begins. In the single-shot mode it lets a trigger that arrives while counting restart the count.

Software arms the channel with a start strobe and halts it with a stop strobe. The compare/data value comes in on `data_i`. Captured counts appear on `capture_o`. Every terminal event produces a one-cycle interrupt pulse and flips the timer output. The trigger and event inputs are level signals, synchronous to the clock, and the channel reacts to their edges.

Top module: `tmr_channel`

## Requirements
- R1: Mode codes are 000 interval, 010 capture, 011 event counter, 100 single-shot, 110 capture single-shot; any other code (001, 101, 111) ignores start, trigger and event inputs: `busy_o` stays 0, no interrupt, `tout_o` unchanged.
- R2: In interval mode, start loads `data_i` into a down-counter; the counter reaching zero gives an interrupt and a reload, so interrupts repeat every `data_i`+1 cycles.
- R3: In interval and capture modes, with detail = 1 the start strobe gives an interrupt and an output toggle in the cycle after start; with detail = 0 neither occurs at start.
- R4: In capture mode the counter counts up from zero after start; a rising trigger edge copies the current count to `capture_o`, raises an interrupt and clears the counter.
- R5: In event counter mode start loads `data_i`; each rising event edge decrements, and the edge seen at zero raises an interrupt and reloads, so every `data_i`+1 edges give one interrupt.
- R6: In single-shot mode start only arms the channel (`busy_o` = 0); a rising trigger edge loads `data_i`, counts down to zero, raises one interrupt and stops until the next trigger edge.
- R7: In single-shot mode with detail = 0 a trigger edge during counting is ignored.
- R8: In single-shot mode with detail = 1 a trigger edge during counting reloads `data_i` and restarts the count with no interrupt at that moment.
- R9: In capture single-shot mode a rising trigger edge starts an up-count from zero and the falling edge copies it to `capture_o`, raises an interrupt and stops; the detail input has no effect and start gives no interrupt and no output change.
- R10: A stop strobe wins over every other input: in the next cycle `busy_o` and `irq_o` are 0, a trigger edge in the same cycle is discarded, and later triggers are ignored until the next start.
- R11: `tout_o` toggles exactly in the cycles where `irq_o` is 1 and holds otherwise.
- R12: After reset `busy_o`, `irq_o`, `tout_o`, `count_o` and `capture_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode code |
| detail_i | input | 1 | Mode detail bit |
| start_i | input | 1 | Software start strobe |
| stop_i | input | 1 | Software stop strobe |
| trig_i | input | 1 | Trigger / capture input level |
| event_i | input | 1 | Event input level |
| data_i | input | W | Compare / reload value |
| count_o | output | W | Current counter value |
| capture_o | output | W | Last captured count |
| irq_o | output | 1 | One-cycle interrupt pulse |
| tout_o | output | 1 | Timer output |
| busy_o | output | 1 | Counter is actively counting |

## Verification
A wrong counter load or a wrong terminal decision shows as an interrupt that arrives early or late. The directed tests measure the interval from each stimulus edge to the pulse, so an off-by-one in reload or trigger latching is seen at the first interrupt. A wrong run or arm flag shows at once on `busy_o`, or as an unwanted pulse within a few cycles of a stop, an illegal code or a retrigger. A wrong captured value shows on `capture_o` in the cycle after the capturing edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    MD_INTERVAL    = 3'b000,
    MD_CAPTURE     = 3'b010,
    MD_EVENT       = 3'b011,
    MD_ONESHOT     = 3'b100,
    MD_CAP_ONESHOT = 3'b110
  } tmr_mode_e;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~q;
    assign fall_o[g] = ~lvl_i[g] & q;
  end
endmodule

// File: rtl/tmr_mode_dec.sv
module tmr_mode_dec
  import tmr_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       detail_i,
  output tmr_mode_e  mode_o,
  output logic       legal_o,
  output logic       start_irq_o,
  output logic       retrig_o
);
  always_comb begin
    mode_o      = tmr_mode_e'(mode_i);
    legal_o     = 1'b0;
    start_irq_o = 1'b0;
    retrig_o    = 1'b0;
    case (mode_i)
      MD_INTERVAL, MD_CAPTURE: begin
        legal_o     = 1'b1;
        start_irq_o = detail_i;
      end
      MD_EVENT:       legal_o = 1'b1;
      MD_ONESHOT: begin
        legal_o  = 1'b1;
        retrig_o = detail_i;
      end
      MD_CAP_ONESHOT: legal_o = 1'b1; // detail ignored here
      default:        legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tmr_mode_e    mode_i,
  input  logic         legal_i,
  input  logic         start_irq_i,
  input  logic         retrig_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         trig_rise_i,
  input  logic         trig_fall_i,
  input  logic         ev_rise_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o,
  output logic         irq_o,
  output logic         tout_o,
  output logic         busy_o
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic         run_q, run_d, act_q, act_d, fire;
  logic [W-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic         irq_q, tout_q;
  logic         at_zero;

  assign at_zero = (cnt_q == ZERO);

  always_comb begin
    run_d = run_q;
    act_d = act_q;
    cnt_d = cnt_q;
    cap_d = cap_q;
    fire  = 1'b0;
    if (stop_i) begin
      run_d = 1'b0;
      act_d = 1'b0;
    end else if (legal_i && start_i) begin
      run_d = 1'b1;
      fire  = start_irq_i;
      case (mode_i)
        MD_INTERVAL, MD_EVENT: begin
          cnt_d = data_i;
          act_d = 1'b1;
        end
        MD_CAPTURE: begin
          cnt_d = ZERO;
          act_d = 1'b1;
        end
        default: act_d = 1'b0; // single-shot modes arm only
      endcase
    end else if (legal_i && run_q) begin
      case (mode_i)
        MD_INTERVAL: begin
          if (at_zero) begin
            cnt_d = data_i;
            fire  = 1'b1;
          end else cnt_d = cnt_q - ONE;
        end
        MD_CAPTURE: begin
          if (trig_rise_i) begin
            cap_d = cnt_q;
            cnt_d = ZERO;
            fire  = 1'b1;
          end else cnt_d = cnt_q + ONE;
        end
        MD_EVENT: begin
          if (ev_rise_i) begin
            if (at_zero) begin
              cnt_d = data_i;
              fire  = 1'b1;
            end else cnt_d = cnt_q - ONE;
          end
        end
        MD_ONESHOT: begin
          if (trig_rise_i && (!act_q || retrig_i)) begin
            cnt_d = data_i;
            act_d = 1'b1;
          end else if (act_q) begin
            if (at_zero) begin
              act_d = 1'b0;
              fire  = 1'b1;
            end else cnt_d = cnt_q - ONE;
          end
        end
        MD_CAP_ONESHOT: begin
          if (!act_q) begin
            if (trig_rise_i) begin
              cnt_d = ZERO;
              act_d = 1'b1;
            end
          end else if (trig_fall_i) begin
            cap_d = cnt_q;
            act_d = 1'b0;
            fire  = 1'b1;
          end else cnt_d = cnt_q + ONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= ZERO;
      cap_q  <= ZERO;
      irq_q  <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      irq_q  <= fire;
      tout_q <= tout_q ^ fire;
    end
  end

  assign cnt_o  = cnt_q;
  assign cap_o  = cap_q;
  assign irq_o  = irq_q;
  assign tout_o = tout_q;
  assign busy_o = run_q & act_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   mode_i,
  input  logic         detail_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         trig_i,
  input  logic         event_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] capture_o,
  output logic         irq_o,
  output logic         tout_o,
  output logic         busy_o
);
  localparam int NIN = 2;
  localparam int TRG = 0;
  localparam int EVT = 1;

  logic [NIN-1:0] rise, fall;
  tmr_mode_e      mode;
  logic           legal, start_irq, retrig;

  tmr_edge_det #(.N(NIN)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({event_i, trig_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_mode_dec i_dec (
    .mode_i      (mode_i),
    .detail_i    (detail_i),
    .mode_o      (mode),
    .legal_o     (legal),
    .start_irq_o (start_irq),
    .retrig_o    (retrig)
  );

  tmr_core #(.W(W)) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .legal_i     (legal),
    .start_irq_i (start_irq),
    .retrig_i    (retrig),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .trig_rise_i (rise[TRG]),
    .trig_fall_i (fall[TRG]),
    .ev_rise_i   (rise[EVT]),
    .data_i      (data_i),
    .cnt_o       (count_o),
    .cap_o       (capture_o),
    .irq_o       (irq_o),
    .tout_o      (tout_o),
    .busy_o      (busy_o)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       detail_i,
  input logic       start_i,
  input logic       stop_i,
  input logic       irq_o,
  input logic       tout_o,
  input logic       busy_o
);
  logic bad_code;
  assign bad_code = (mode_i == 3'b001) || (mode_i == 3'b101) || (mode_i == 3'b111);

  p_illegal_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_code && !busy_o) |=> (!busy_o && !irq_o));

  p_start_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b000 && detail_i && start_i && !stop_i) |=> (irq_o && busy_o));

  p_cap_oneshot_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b110 && start_i && !stop_i && !busy_o) |=> !irq_o);

  p_stop_halts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!busy_o && !irq_o));

  p_tout_on_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (tout_o != $past(tout_o)));

  p_tout_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> $stable(tout_o));
endmodule

bind tmr_channel tmr_channel_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .detail_i (detail_i),
  .start_i  (start_i),
  .stop_i   (stop_i),
  .irq_o    (irq_o),
  .tout_o   (tout_o),
  .busy_o   (busy_o)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int WATCHDOG = 50000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   mode = 3'b000;
  logic         detail = 1'b0, start = 1'b0, stop = 1'b0, trig = 1'b0, ev = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] count, cap;
  logic         irq, tout, busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_channel #(.W(W)) i_tmr_channel (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .detail_i(detail),
    .start_i(start), .stop_i(stop), .trig_i(trig), .event_i(ev),
    .data_i(data), .count_o(count), .capture_o(cap), .irq_o(irq),
    .tout_o(tout), .busy_o(busy)
  );

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1; @(negedge clk); trig = 1'b0;
  endtask

  task automatic to_irq(input int lim, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < lim);
  endtask

  task automatic no_irq_for(input int k, input string req);
    int seen = 0;
    repeat (k) begin @(negedge clk); if (irq) seen++; end
    cmp(seen, 0, req, "interrupts in quiet window");
  endtask

  task automatic t_reset();
    cmp(busy, 0, "R12", "busy after reset");
    cmp(irq, 0, "R12", "irq after reset");
    cmp(tout, 0, "R12", "tout after reset");
    cmp(count, 0, "R12", "count after reset");
    cmp(cap, 0, "R12", "capture after reset");
  endtask

  task automatic t_interval(input logic d);
    int n;
    logic t0;
    pulse_stop();
    mode = 3'b000; detail = d; data = 16'd3; t0 = tout;
    pulse_start();
    cmp(irq, d, "R3", "interval start interrupt");
    cmp(tout, t0 ^ d, "R3", "interval start toggle");
    to_irq(50, n);
    cmp(n, 4, "R2", "interval first period");
    cmp(tout, t0 ^ d ^ 1'b1, "R11", "toggle on interval interrupt");
    to_irq(50, n);
    cmp(n, 4, "R2", "interval reload period");
  endtask

  task automatic t_capture(input logic d);
    pulse_stop();
    mode = 3'b010; detail = d;
    pulse_start();
    cmp(irq, d, "R3", "capture start interrupt");
    repeat (7) @(negedge clk);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    cmp(irq, 1, "R4", "capture interrupt");
    cmp(cap, 7, "R4", "first captured count");
    repeat (12) @(negedge clk);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    cmp(cap, 12, "R4", "count cleared after capture");
  endtask

  task automatic t_event();
    pulse_stop();
    mode = 3'b011; detail = 1'b0; data = 16'd2;
    pulse_start();
    cmp(irq, 0, "R5", "no interrupt at event start");
    for (int r = 0; r < 2; r++) begin
      for (int i = 1; i <= 3; i++) begin
        ev = 1'b1; @(negedge clk); ev = 1'b0;
        cmp(irq, (i == 3), "R5", $sformatf("event edge %0d round %0d", i, r));
        repeat (2) @(negedge clk);
      end
    end
  endtask

  task automatic t_oneshot();
    int n;
    pulse_stop();
    mode = 3'b100; detail = 1'b0; data = 16'd2;
    pulse_start();
    cmp(busy, 0, "R6", "armed but idle");
    no_irq_for(4, "R6");
    pulse_trig();
    cmp(busy, 1, "R6", "counting after trigger");
    to_irq(50, n);
    cmp(n, 3, "R6", "single-shot delay");
    cmp(busy, 0, "R6", "stopped after shot");
    no_irq_for(6, "R6");
    pulse_trig();
    to_irq(50, n);
    cmp(n, 3, "R6", "second shot delay");
  endtask

  task automatic t_retrig(input logic d);
    int n;
    pulse_stop();
    mode = 3'b100; detail = d; data = 16'd5;
    pulse_start();
    pulse_trig();
    repeat (2) @(negedge clk);
    pulse_trig();
    to_irq(50, n);
    if (d) cmp(n, 6, "R8", "retrigger restarts count");
    else   cmp(n, 3, "R7", "retrigger ignored");
  endtask

  task automatic t_cap_oneshot();
    logic t0;
    pulse_stop();
    mode = 3'b110; detail = 1'b1; t0 = tout;
    pulse_start();
    cmp(irq, 0, "R9", "no start interrupt");
    cmp(tout, t0, "R9", "no start toggle");
    trig = 1'b1;
    repeat (6) @(negedge clk);
    trig = 1'b0; @(negedge clk);
    cmp(irq, 1, "R9", "interrupt at falling edge");
    cmp(cap, 5, "R9", "pulse width capture");
    cmp(busy, 0, "R9", "stopped after capture");
  endtask

  task automatic t_stop();
    pulse_stop();
    mode = 3'b000; detail = 1'b0; data = 16'd10;
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_stop();
    cmp(busy, 0, "R10", "stop halts interval");
    no_irq_for(25, "R10");
    mode = 3'b100; data = 16'd2;
    pulse_start();
    stop = 1'b1; trig = 1'b1; @(negedge clk); stop = 1'b0; trig = 1'b0;
    cmp(busy, 0, "R10", "trigger with stop discarded");
    no_irq_for(8, "R10");
    pulse_trig();
    cmp(busy, 0, "R10", "trigger after stop ignored");
  endtask

  task automatic t_illegal(input logic [2:0] code);
    logic t0;
    pulse_stop();
    mode = code; detail = 1'b1; data = 16'd1; t0 = tout;
    pulse_start();
    cmp(busy, 0, "R1", $sformatf("code %0d start ignored", code));
    pulse_trig();
    ev = 1'b1; @(negedge clk); ev = 1'b0;
    no_irq_for(6, "R1");
    cmp(tout, t0, "R1", "tout unchanged in bad mode");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interval(1'b0);
    t_interval(1'b1);
    t_capture(1'b0);
    t_capture(1'b1);
    t_event();
    t_oneshot();
    t_retrig(1'b0);
    t_retrig(1'b1);
    t_cap_oneshot();
    t_stop();
    t_illegal(3'b001);
    t_illegal(3'b101);
    t_illegal(3'b111);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule